// File: doc/BRIEF.md
# Priority Interrupt Controller with Sequential and Nested Service

This block collects interrupt requests from four source classes (hardware failure, program error, timer and I/O) and presents one request line and a 2-bit vector index to a processor. A request is captured when its source line rises and waits as pending until the processor acknowledges it. On acknowledge, the level moves from pending to in-service. The processor signals the end of each handler, and the controller then retires the highest active level.

A mode select picks between two service schemes. In sequential mode, no new request reaches the processor while any handler is active. Captured requests wait and are served one at a time, in priority order, once the active handler ends. In nested mode, a pending request goes to the processor only when it outranks every active level. Ending the preempting handler returns service to the level it interrupted.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no level is pending or in service, and `intReq` is low.
- R2: A source is captured only on a rising edge of its request line. A line held high is captured once. A one-cycle pulse stays pending after the line falls.
- R3: The source bits are mapped as follows, from highest to lowest priority: bit 3 is hardware failure (vector 3), bit 2 is program error (vector 2), bit 1 is timer (vector 1) and bit 0 is I/O (vector 0). When a request is raised, `intVec` gives the highest pending level.
- R4: `intAck` while `intReq` is high clears that level's pending bit and marks the level in service. `intAck` while `intReq` is low has no effect.
- R5: In sequential mode (`nestMode`=0), `intReq` stays low while any level is in service, and captured requests remain pending.
- R6: In sequential mode, pending levels are presented one at a time after each handler ends, highest priority first.
- R7: In nested mode (`nestMode`=1), a pending level above the highest in-service level raises `intReq` while that handler is still active.
- R8: In nested mode, a pending level equal to or below the highest in-service level does not raise `intReq`.
- R9: `handlerDone` clears only the highest in-service level, which makes the previously interrupted level the active one again.
- R10: `nestMode` is applied without delay: changing it immediately re-evaluates whether a waiting request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | 4 | Request line per source class, mapped as in R3 |
| nestMode | input | 1 | 1 selects nested service, 0 selects sequential |
| intAck | input | 1 | Processor accepts the presented request |
| handlerDone | input | 1 | Processor has finished the current handler |
| intReq | output | 1 | Interrupt request to the processor |
| intVec | output | 2 | Index of the presented level |

## Verification
The bench holds a source line high across an acknowledge and a handler end. A design that captured levels instead of edges would raise the same request again. It fires all four sources in the same cycle and drains them in sequential mode; a wrong priority encoder would serve them out of order. In nested mode it sends an equal-level and a lower-level request during an active handler, then ends the inner handler. A controller that compared with `>=`, or that retired the lowest level instead of the highest, would preempt wrongly or return to the wrong level. It also acknowledges while nothing is presented and flips the mode while a request waits, which catches phantom in-service bits and a mode select that acts late.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_N = 4;
  localparam int VEC_W = $clog2(SRC_N);

  typedef struct packed {
    logic take;    // move the presented level from pending to in-service
    logic retire;  // drop the highest in-service level
  } ctrlStrobes_t;
endpackage

// File: rtl/irqc_prienc.sv
module irqc_prienc #(
  parameter int WIDTH = 4,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic             anySet,
  output logic [IDX_W-1:0] topIdx
);
  always_comb begin
    anySet = 1'b0;
    topIdx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vecIn[i]) begin
        anySet = 1'b1;
        topIdx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int SRC_W = SRC_N,
  localparam int IDX_W = $clog2(SRC_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_W-1:0] srcReq,
  input  ctrlStrobes_t     strb,
  input  logic [IDX_W-1:0] grantIdx,
  output logic [SRC_W-1:0] pendingVec,
  output logic [SRC_W-1:0] inServiceVec
);
  logic [SRC_W-1:0] srcPrev;
  logic [SRC_W-1:0] riseVec;
  logic [SRC_W-1:0] takeMask;
  logic [SRC_W-1:0] retireMask;
  logic             svcAny;
  logic [IDX_W-1:0] svcTop;

  assign riseVec = srcReq & ~srcPrev;

  irqc_prienc #(.WIDTH(SRC_W)) u_svcEnc (
    .vecIn (inServiceVec),
    .anySet(svcAny),
    .topIdx(svcTop)
  );

  genvar g;
  generate
    for (g = 0; g < SRC_W; g++) begin : gMask
      assign takeMask[g]   = strb.take && (grantIdx == IDX_W'(g));
      assign retireMask[g] = strb.retire && svcAny && (svcTop == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPrev      <= '0;
      pendingVec   <= '0;
      inServiceVec <= '0;
    end else begin
      srcPrev      <= srcReq;
      pendingVec   <= (pendingVec & ~takeMask) | riseVec;
      inServiceVec <= (inServiceVec & ~retireMask) | takeMask;
    end
  end
endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
#(
  parameter int SRC_W = SRC_N,
  localparam int IDX_W = $clog2(SRC_W)
) (
  input  logic [SRC_W-1:0] pendingVec,
  input  logic [SRC_W-1:0] inServiceVec,
  input  logic             nestMode,
  input  logic             intAck,
  input  logic             handlerDone,
  output ctrlStrobes_t     strb,
  output logic [IDX_W-1:0] grantIdx,
  output logic             intReq,
  output logic [IDX_W-1:0] intVec
);
  logic             pendAny;
  logic [IDX_W-1:0] pendTop;
  logic             svcAny;
  logic [IDX_W-1:0] svcTop;
  logic             allowed;

  irqc_prienc #(.WIDTH(SRC_W)) u_pendEnc (
    .vecIn (pendingVec),
    .anySet(pendAny),
    .topIdx(pendTop)
  );

  irqc_prienc #(.WIDTH(SRC_W)) u_svcEnc (
    .vecIn (inServiceVec),
    .anySet(svcAny),
    .topIdx(svcTop)
  );

  always_comb begin
    if (nestMode) allowed = !svcAny || (pendTop > svcTop);
    else          allowed = !svcAny;
    intReq      = pendAny && allowed;
    intVec      = pendTop;
    grantIdx    = pendTop;
    strb.take   = intReq && intAck;
    strb.retire = handlerDone && svcAny;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int SRC_W = SRC_N,
  localparam int IDX_W = $clog2(SRC_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_W-1:0] srcReq,
  input  logic             nestMode,
  input  logic             intAck,
  input  logic             handlerDone,
  output logic             intReq,
  output logic [IDX_W-1:0] intVec
);
  ctrlStrobes_t     strb;
  logic [IDX_W-1:0] grantIdx;
  logic [SRC_W-1:0] pendingVec;
  logic [SRC_W-1:0] inServiceVec;

  irqc_datapath #(.SRC_W(SRC_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .srcReq      (srcReq),
    .strb        (strb),
    .grantIdx    (grantIdx),
    .pendingVec  (pendingVec),
    .inServiceVec(inServiceVec)
  );

  irqc_control #(.SRC_W(SRC_W)) u_ctl (
    .pendingVec  (pendingVec),
    .inServiceVec(inServiceVec),
    .nestMode    (nestMode),
    .intAck      (intAck),
    .handlerDone (handlerDone),
    .strb        (strb),
    .grantIdx    (grantIdx),
    .intReq      (intReq),
    .intVec      (intVec)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int SRC_W = 4,
  localparam int IDX_W = $clog2(SRC_W)
) (
  input logic             clk,
  input logic             rstN,
  input logic             nestMode,
  input logic             intAck,
  input logic             handlerDone,
  input logic             intReq,
  input logic [IDX_W-1:0] intVec,
  input logic [SRC_W-1:0] pendingVec,
  input logic [SRC_W-1:0] inServiceVec
);
  assert_seq_block_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!nestMode && (|inServiceVec)) |-> !intReq);

  assert_req_is_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> pendingVec[intVec]);

  assert_ack_enters_service_R4: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intAck) |=> inServiceVec[$past(intVec)]);

  assert_idle_ack_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intReq && !handlerDone) |=> (inServiceVec == $past(inServiceVec)));

  assert_done_drops_one_R9: assert property (@(posedge clk) disable iff (!rstN)
    (handlerDone && !(intReq && intAck) && (|inServiceVec)) |=>
      ($countones(inServiceVec) == $countones($past(inServiceVec)) - 1));

  assert_nest_outranks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (nestMode && intReq) |-> ((inServiceVec >> intVec) == '0));
endmodule

bind prio_irq_ctrl irqc_checker #(.SRC_W(SRC_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .nestMode    (nestMode),
  .intAck      (intAck),
  .handlerDone (handlerDone),
  .intReq      (intReq),
  .intVec      (intVec),
  .pendingVec  (pendingVec),
  .inServiceVec(inServiceVec)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] srcReq = '0;
  logic       nestMode = 1'b0;
  logic       intAck = 1'b0;
  logic       handlerDone = 1'b0;
  logic       intReq;
  logic [1:0] intVec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .nestMode(nestMode),
    .intAck(intAck), .handlerDone(handlerDone), .intReq(intReq), .intVec(intVec)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectReq(input logic expReq, input logic [1:0] expVec, input string tag);
    checks++;
    if (intReq !== expReq || (expReq && intVec !== expVec)) begin
      errors++;
      $display("FAIL %s: intReq=%0b intVec=%0d expected intReq=%0b intVec=%0d",
               tag, intReq, intVec, expReq, expVec);
    end
  endtask

  task automatic pulseSrc(input logic [3:0] bits);
    srcReq = bits; tick(); srcReq = '0;
  endtask

  task automatic doAck();
    intAck = 1'b1; tick(); intAck = 1'b0;
  endtask

  task automatic doDone();
    handlerDone = 1'b1; tick(); handlerDone = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0; tick(); tick(); rstN = 1'b1; tick();
    expectReq(1'b0, 2'd0, "R1 reset idle");
  endtask

  task automatic t_edge();
    nestMode = 1'b0;
    srcReq[1] = 1'b1; tick();
    expectReq(1'b1, 2'd1, "R2 rise captured");
    doAck();
    doDone();
    expectReq(1'b0, 2'd0, "R2 held level not recaptured");
    srcReq[1] = 1'b0; tick();
    pulseSrc(4'b0001); tick(); tick();
    expectReq(1'b1, 2'd0, "R2 pulse kept pending");
    doAck(); doDone();
  endtask

  task automatic t_prio();
    nestMode = 1'b0;
    pulseSrc(4'b1111);
    expectReq(1'b1, 2'd3, "R3 hw failure first");
    doAck(); doDone();
    expectReq(1'b1, 2'd2, "R6 program second");
    doAck(); doDone();
    expectReq(1'b1, 2'd1, "R6 timer third");
    doAck(); doDone();
    expectReq(1'b1, 2'd0, "R6 io last");
    doAck(); doDone();
    expectReq(1'b0, 2'd0, "R6 drained");
  endtask

  task automatic t_seq();
    nestMode = 1'b0;
    pulseSrc(4'b0001); doAck();
    pulseSrc(4'b1000);
    expectReq(1'b0, 2'd0, "R5 blocked while servicing");
    tick();
    expectReq(1'b0, 2'd0, "R5 still blocked");
    doDone();
    expectReq(1'b1, 2'd3, "R6 pending served after done");
    doAck(); doDone();
    expectReq(1'b0, 2'd0, "R6 empty after service");
  endtask

  task automatic t_idleAck();
    nestMode = 1'b0;
    doAck();
    pulseSrc(4'b0010);
    expectReq(1'b1, 2'd1, "R4 idle ack ignored");
    doAck();
    expectReq(1'b0, 2'd0, "R4 ack moved level to service");
    doDone();
    expectReq(1'b0, 2'd0, "R4 pending cleared by ack");
  endtask

  task automatic t_nest();
    nestMode = 1'b1;
    pulseSrc(4'b0001); doAck();
    pulseSrc(4'b0100);
    expectReq(1'b1, 2'd2, "R7 program preempts io");
    doAck();
    pulseSrc(4'b0010);
    expectReq(1'b0, 2'd0, "R8 timer below program held");
    doDone();
    expectReq(1'b1, 2'd1, "R9 back to io level, timer outranks");
    doAck(); doDone();
    expectReq(1'b0, 2'd0, "R9 io active again, nothing raised");
    doDone();
    expectReq(1'b0, 2'd0, "R9 all retired");
    nestMode = 1'b0;
  endtask

  task automatic t_equal();
    nestMode = 1'b1;
    pulseSrc(4'b0100); doAck();
    pulseSrc(4'b0100);
    expectReq(1'b0, 2'd0, "R8 equal level held");
    doDone();
    expectReq(1'b1, 2'd2, "R8 equal level after done");
    doAck(); doDone();
    nestMode = 1'b0;
  endtask

  task automatic t_mode();
    nestMode = 1'b0;
    pulseSrc(4'b0001); doAck();
    pulseSrc(4'b1000);
    expectReq(1'b0, 2'd0, "R10 sequential blocks");
    nestMode = 1'b1; #1;
    expectReq(1'b1, 2'd3, "R10 nested raises at once");
    @(negedge clk);
    doAck(); doDone(); doDone();
    expectReq(1'b0, 2'd0, "R10 cleanup");
    nestMode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_edge();
    t_prio();
    t_seq();
    t_idleAck();
    t_nest();
    t_equal();
    t_mode();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule